// File: doc/BRIEF.md
# Pipeline Stage Skid-Buffer Controller

This block is the per-thread flow controller for a middle stage of an instruction pipeline. Each cycle an upstream queue presents up to `FW` opaque tokens, packed from lane 0. The controller forwards up to `W` of them, in order, into a registered downstream slot. Three downstream stall sources each send one-cycle set and clear pulses. A local latch per source remembers whether that source is holding the stage.

When the stage cannot forward everything it receives, it parks the tokens in a skid buffer and sends a one-cycle block pulse upstream. There are two such cases: a stall, or more tokens than `W`. Once every stall latch is clear, the controller enters a drain phase. In this phase it forwards only from the head of the skid buffer and appends any new arrivals to the tail. When the skid buffer runs dry, it sends a one-cycle unblock pulse upstream. A full squash flushes everything. A "squash in progress" indication keeps the stage quiet until it drops.

The skid buffer holds `(LAT+1)*FW` tokens, where `LAT` is the upstream-to-stage latency in cycles. Two internal flops release the reset synchronously, so the stage starts acting two clock edges after `rst_n` rises.

Top module: `skid_stage_ctrl`

## Requirements
- R1: While reset is applied, and after it: `state_o` is Idle (0), `out_cnt` is 0, `up_block`, `up_unblock` and `ovf_err` are 0, `skid_empty` is 1 and `skid_full` is 0. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: The stage may be in Idle, Running, or Squashing with the squash ended. In these states, if no stall is latched, the first min(`in_cnt`,W) input lanes appear one clock later on `out_cnt`/`out_tok`, lane 0 first. Lane k sits at bits [k*TOK_W +: TOK_W]. The state becomes Running once anything is forwarded.
- R3: If more than W tokens arrive in such a cycle, the excess (input lanes W and up) enters the skid buffer in lane order. The state becomes Blocked and `up_block` pulses for one cycle.
- R4: A set pulse on source i latches stall i, and a clear pulse releases it; if both arrive in one cycle, the clear wins. While any latch is set, all arrivals go to the skid buffer, nothing is forwarded, and the state is Blocked. `up_block` pulses only if the previous state was neither Blocked nor Unblocking.
- R5: In the first unstalled cycle after Blocked, the state becomes Unblocking, and up to W tokens are forwarded from the skid head in that same cycle. While Unblocking, new arrivals are appended behind older skid contents and are never forwarded ahead of them.
- R6: Unblocking ends in the cycle where the skid buffer holds at most W tokens and nothing arrives. That cycle forwards the remaining tokens, pulses `up_unblock` and enters Running.
- R7: `squash_all` takes priority over everything else. It empties the skid buffer, discards that cycle's arrivals and enters Squashing. It pulses `up_unblock` if the previous state was Blocked or Unblocking.
- R8: While `squash_busy` is high (and `squash_all` is not), the state is Squashing, nothing is forwarded and arrivals are dropped. The first cycle without either squash input leaves Squashing and handles arrivals as in R2/R3.
- R9: The skid capacity is (LAT+1)*FW. Arrivals beyond the free space are dropped, and `ovf_err` rises and stays high until reset. `skid_full` is high when the skid buffer holds exactly capacity tokens.
- R10: The squash inputs take priority over the stall latches. A stall set in the same cycle as `squash_all` is still latched and blocks the next unsquashed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cnt | input | clog2(FW+1) | Number of valid tokens on `in_tok` this cycle |
| in_tok | input | FW*TOK_W | Arriving tokens, lane 0 oldest |
| stall_set | input | NSRC | Per-source stall set pulses |
| stall_clr | input | NSRC | Per-source stall release pulses |
| squash_all | input | 1 | Full flush of this thread |
| squash_busy | input | 1 | Downstream squash still in progress |
| out_cnt | output | clog2(W+1) | Tokens forwarded into the downstream slot |
| out_tok | output | W*TOK_W | Forwarded tokens, lane 0 oldest |
| up_block | output | 1 | One-cycle request for upstream to hold |
| up_unblock | output | 1 | One-cycle release of upstream |
| state_o | output | 3 | Current state code |
| skid_empty | output | 1 | Skid buffer holds no tokens |
| skid_full | output | 1 | Skid buffer at capacity |
| ovf_err | output | 1 | Sticky skid overflow flag |

## Verification
The bench uses the default parameters: W=2, FW=4, LAT=1 and TOK_W=8, which give an 8-token skid buffer. Because the upstream is twice as wide as the stage, a single burst already forces an excess-driven block. A drain then spans several cycles, so tokens appended during Unblocking can be watched queuing behind older ones. The buffer is small enough to overflow after three stalled four-token bursts. A short replay then shows that exactly the first eight tokens survive, in order.

// File: rtl/skidctl_pkg.sv
package skidctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } st_e;
endpackage

// File: rtl/skidctl_stall.sv
module skidctl_stall #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic            stalled_o
);
  logic [NSRC-1:0] lat_q, lat_d;

  // set first, then release: a release in the same cycle wins
  always_comb begin
    lat_d     = (lat_q | set_i) & ~clr_i;
    stalled_o = |lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/skidctl_fifo.sv
module skidctl_fifo #(
  parameter int DEPTH = 8,
  parameter int TOK_W = 8,
  parameter int RD_N  = 2,
  parameter int WR_N  = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic [CW-1:0]         pop_i,
  input  logic [CW-1:0]         push_i,
  input  logic [WR_N*TOK_W-1:0] push_tok_i,
  output logic [RD_N*TOK_W-1:0] head_o,
  output logic [CW-1:0]         cnt_o,
  output logic                  ovf_o
);
  logic [TOK_W-1:0] mem_q [DEPTH];
  logic [TOK_W-1:0] mem_d [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d, kept, space, acc;
  logic             mem_en;

  always_comb begin
    kept   = cnt_q - pop_i;
    space  = CW'(DEPTH) - kept;
    ovf_o  = push_i > space;
    acc    = ovf_o ? space : push_i;
    cnt_d  = clr_i ? '0 : kept + acc;
    mem_en = !clr_i && ((pop_i != '0) || (acc != '0));
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (i < int'(kept)) begin
        if (i + int'(pop_i) < DEPTH) mem_d[i] = mem_q[i + int'(pop_i)];
      end else if ((i - int'(kept) < int'(acc)) && (i - int'(kept) < WR_N)) begin
        mem_d[i] = push_tok_i[(i - int'(kept))*TOK_W +: TOK_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (mem_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar k = 0; k < RD_N; k++) begin : g_head
    assign head_o[k*TOK_W +: TOK_W] = mem_q[k];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/skid_stage_ctrl.sv
module skid_stage_ctrl
  import skidctl_pkg::*;
#(
  parameter int W     = 2,
  parameter int FW    = 4,
  parameter int LAT   = 1,
  parameter int TOK_W = 8,
  parameter int NSRC  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(FW+1)-1:0]  in_cnt,
  input  logic [FW*TOK_W-1:0]      in_tok,
  input  logic [NSRC-1:0]          stall_set,
  input  logic [NSRC-1:0]          stall_clr,
  input  logic                     squash_all,
  input  logic                     squash_busy,
  output logic [$clog2(W+1)-1:0]   out_cnt,
  output logic [W*TOK_W-1:0]       out_tok,
  output logic                     up_block,
  output logic                     up_unblock,
  output logic [2:0]               state_o,
  output logic                     skid_empty,
  output logic                     skid_full,
  output logic                     ovf_err
);
  localparam int CAP    = (LAT + 1) * FW;
  localparam int CW     = $clog2(CAP + 1);
  localparam int OUT_CW = $clog2(W + 1);
  localparam logic [CW-1:0] W_C = CW'(W);

  logic [1:0]          rs_q;
  logic                rst_int_n;
  st_e                 state_q, state_d;
  logic                stalled, clr, push_off, fwd_skid, blk_d, unb_d, fifo_ovf, ovf_q;
  logic [CW-1:0]       in_c, skid_cnt, pop_n, push_n;
  logic [OUT_CW-1:0]   fwd_n;
  logic [W*TOK_W-1:0]  head_tok, out_tok_d;
  logic [FW*TOK_W-1:0] push_tok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  skidctl_stall #(.NSRC(NSRC)) u_stall (
    .clk(clk), .rst_n(rst_int_n), .set_i(stall_set), .clr_i(stall_clr),
    .stalled_o(stalled)
  );

  skidctl_fifo #(.DEPTH(CAP), .TOK_W(TOK_W), .RD_N(W), .WR_N(FW), .CW(CW)) u_skid (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr), .pop_i(pop_n), .push_i(push_n),
    .push_tok_i(push_tok), .head_o(head_tok), .cnt_o(skid_cnt), .ovf_o(fifo_ovf)
  );

  assign in_c = CW'(in_cnt);

  // priority: full squash, squash in progress, stall, drain, normal flow
  always_comb begin
    state_d  = state_q;
    clr      = 1'b0;
    push_off = 1'b0;
    fwd_skid = 1'b0;
    blk_d    = 1'b0;
    unb_d    = 1'b0;
    pop_n    = '0;
    push_n   = '0;
    fwd_n    = '0;
    if (squash_all) begin
      clr     = 1'b1;
      unb_d   = (state_q == ST_BLK) || (state_q == ST_UNB);
      state_d = ST_SQ;
    end else if (squash_busy) begin
      state_d = ST_SQ;
    end else if (stalled) begin
      push_n  = in_c;
      blk_d   = !((state_q == ST_BLK) || (state_q == ST_UNB));
      state_d = ST_BLK;
    end else if ((state_q == ST_BLK) || (state_q == ST_UNB)) begin
      fwd_skid = 1'b1;
      pop_n    = (skid_cnt > W_C) ? W_C : skid_cnt;
      fwd_n    = OUT_CW'(pop_n);
      push_n   = in_c;
      if ((skid_cnt <= W_C) && (in_c == '0)) begin
        unb_d   = 1'b1;
        state_d = ST_RUN;
      end else begin
        state_d = ST_UNB;
      end
    end else begin
      fwd_n = (in_c > W_C) ? OUT_CW'(W) : OUT_CW'(in_c);
      if (in_c > W_C) begin
        push_off = 1'b1;
        push_n   = in_c - W_C;
        blk_d    = 1'b1;
        state_d  = ST_BLK;
      end else if ((in_c != '0) || (state_q == ST_SQ)) begin
        state_d = ST_RUN;
      end
    end
  end

  assign push_tok = push_off ? (in_tok >> (W*TOK_W)) : in_tok;

  for (genvar k = 0; k < W; k++) begin : g_lane
    assign out_tok_d[k*TOK_W +: TOK_W] =
      (fwd_n > OUT_CW'(k)) ? (fwd_skid ? head_tok[k*TOK_W +: TOK_W]
                                       : in_tok[k*TOK_W +: TOK_W])
                           : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      out_cnt    <= '0;
      out_tok    <= '0;
      up_block   <= 1'b0;
      up_unblock <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      out_cnt    <= fwd_n;
      up_block   <= blk_d;
      up_unblock <= unb_d;
      if (fifo_ovf) ovf_q <= 1'b1;
      if (fwd_n != '0) out_tok <= out_tok_d;
    end
  end

  assign state_o    = state_q;
  assign ovf_err    = ovf_q;
  assign skid_empty = (skid_cnt == '0);
  assign skid_full  = (skid_cnt == CW'(CAP));
endmodule

// File: rtl/skidctl_chk.sv
module skidctl_chk #(
  parameter int W    = 2,
  parameter int NSRC = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   squash_all,
  input logic                   squash_busy,
  input logic [NSRC-1:0]        stall_set,
  input logic [NSRC-1:0]        stall_clr,
  input logic [2:0]             state_o,
  input logic [$clog2(W+1)-1:0] out_cnt,
  input logic                   up_block,
  input logic                   up_unblock,
  input logic                   skid_empty,
  input logic                   skid_full,
  input logic                   ovf_err
);
  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_block && up_unblock));

  p_block_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_block |-> state_o == 3'd2);

  p_unblock_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_unblock |-> (state_o == 3'd1 || state_o == 3'd4));

  p_lane_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_cnt) <= W);

  p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(stall_set & ~stall_clr)) && !squash_all && !squash_busy) |=> state_o == 3'd2);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    squash_all |=> (skid_empty && state_o == 3'd4 && out_cnt == '0));

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_busy && !squash_all) |=> (state_o == 3'd4 && out_cnt == '0));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_full_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    skid_full |-> !skid_empty);
endmodule

bind skid_stage_ctrl skidctl_chk #(.W(W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .squash_all(squash_all), .squash_busy(squash_busy),
  .stall_set(stall_set), .stall_clr(stall_clr), .state_o(state_o), .out_cnt(out_cnt),
  .up_block(up_block), .up_unblock(up_unblock), .skid_empty(skid_empty),
  .skid_full(skid_full), .ovf_err(ovf_err)
);

// File: tb/tb_skid_stage_ctrl.sv
`timescale 1ns/1ps
module tb_skid_stage_ctrl;
  localparam int W = 2, FW = 4, LAT = 1, TOK_W = 8, NSRC = 3;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] n_in;
    logic [7:0] base;
    logic [2:0] set;
    logic [2:0] clr;
    logic       sqa;
    logic       sqb;
    logic [2:0] e_st;
    logic [1:0] e_n;
    logic [7:0] e_t0;
    logic [7:0] e_t1;
    logic       e_blk;
    logic       e_unb;
    logic       e_emp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  3'd2, 8'h10, 3'd0, 3'd0, 1'b0, 1'b0, 3'd1, 2'd2, 8'h10, 8'h11, 1'b0, 1'b0, 1'b1},
    '{4'd2,  3'd1, 8'h20, 3'd0, 3'd0, 1'b0, 1'b0, 3'd1, 2'd1, 8'h20, 8'h00, 1'b0, 1'b0, 1'b1},
    '{4'd3,  3'd4, 8'h30, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2, 2'd2, 8'h30, 8'h31, 1'b1, 1'b0, 1'b0},
    '{4'd5,  3'd0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 3'd1, 2'd2, 8'h32, 8'h33, 1'b0, 1'b1, 1'b1},
    '{4'd4,  3'd3, 8'h40, 3'd1, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},
    '{4'd4,  3'd2, 8'h50, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    '{4'd5,  3'd0, 8'h00, 3'd0, 3'd1, 1'b0, 1'b0, 3'd3, 2'd2, 8'h40, 8'h41, 1'b0, 1'b0, 1'b0},
    '{4'd5,  3'd1, 8'h60, 3'd0, 3'd0, 1'b0, 1'b0, 3'd3, 2'd2, 8'h42, 8'h50, 1'b0, 1'b0, 1'b0},
    '{4'd6,  3'd0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 3'd1, 2'd2, 8'h51, 8'h60, 1'b0, 1'b1, 1'b1},
    '{4'd4,  3'd0, 8'h00, 3'd6, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1},
    '{4'd4,  3'd0, 8'h00, 3'd0, 3'd2, 1'b0, 1'b0, 3'd2, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
    '{4'd4,  3'd0, 8'h00, 3'd1, 3'd5, 1'b0, 1'b0, 3'd1, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},
    '{4'd4,  3'd4, 8'h70, 3'd1, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},
    '{4'd7,  3'd2, 8'h78, 3'd0, 3'd1, 1'b1, 1'b0, 3'd4, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},
    '{4'd8,  3'd3, 8'h80, 3'd0, 3'd0, 1'b0, 1'b1, 3'd4, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
    '{4'd8,  3'd3, 8'h90, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2, 2'd2, 8'h90, 8'h91, 1'b1, 1'b0, 1'b0},
    '{4'd10, 3'd0, 8'h00, 3'd2, 3'd0, 1'b1, 1'b0, 3'd4, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},
    '{4'd10, 3'd1, 8'hA0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},
    '{4'd6,  3'd0, 8'h00, 3'd0, 3'd2, 1'b0, 1'b0, 3'd1, 2'd1, 8'hA0, 8'h00, 1'b0, 1'b1, 1'b1}
  };

  logic                    clk, rst_n;
  logic [$clog2(FW+1)-1:0] in_cnt;
  logic [FW*TOK_W-1:0]     in_tok;
  logic [NSRC-1:0]         stall_set, stall_clr;
  logic                    squash_all, squash_busy;
  logic [$clog2(W+1)-1:0]  out_cnt;
  logic [W*TOK_W-1:0]      out_tok;
  logic                    up_block, up_unblock, skid_empty, skid_full, ovf_err;
  logic [2:0]              state_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  skid_stage_ctrl #(.W(W), .FW(FW), .LAT(LAT), .TOK_W(TOK_W), .NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_tok(in_tok),
    .stall_set(stall_set), .stall_clr(stall_clr), .squash_all(squash_all),
    .squash_busy(squash_busy), .out_cnt(out_cnt), .out_tok(out_tok),
    .up_block(up_block), .up_unblock(up_unblock), .state_o(state_o),
    .skid_empty(skid_empty), .skid_full(skid_full), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input int n, input logic [7:0] base, input logic [2:0] s,
                       input logic [2:0] c, input logic sa, input logic sb);
    @(negedge clk);
    in_cnt = 3'(n);
    for (int k = 0; k < FW; k++)
      in_tok[k*TOK_W +: TOK_W] = (k < n) ? base + 8'(k) : 8'h00;
    stall_set   = s;
    stall_clr   = c;
    squash_all  = sa;
    squash_busy = sb;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [2:0] st, input int n,
                            input logic [7:0] t0, input logic [7:0] t1,
                            input logic blk, input logic unb, input logic emp);
    logic bad;
    n_checks++;
    bad = (state_o != st) || (int'(out_cnt) != n) || (up_block != blk) ||
          (up_unblock != unb) || (skid_empty != emp) ||
          (n > 0 && out_tok[7:0] != t0) || (n > 1 && out_tok[15:8] != t1);
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got st=%0d n=%0d tok=%h,%h blk=%b unb=%b emp=%b; want st=%0d n=%0d tok=%h,%h blk=%b unb=%b emp=%b",
               tag, state_o, out_cnt, out_tok[7:0], out_tok[15:8], up_block, up_unblock,
               skid_empty, st, n, t0, t1, blk, unb, emp);
    end
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b want %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    // R1: outputs quiet while reset is applied
    expect_out("R1 during reset", 3'd0, 0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    expect_bit("R1 ovf in reset", ovf_err, 1'b0);
    expect_bit("R1 full in reset", skid_full, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1 after release", 3'd0, 0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b1; in_cnt = '0; in_tok = '0; stall_set = '0; stall_clr = '0;
    squash_all = 1'b0; squash_busy = 1'b0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      drive(int'(VECS[i].n_in), VECS[i].base, VECS[i].set, VECS[i].clr,
            VECS[i].sqa, VECS[i].sqb);
      expect_out($sformatf("%s vec %0d", req_name(VECS[i].req), i), VECS[i].e_st,
                 int'(VECS[i].e_n), VECS[i].e_t0, VECS[i].e_t1,
                 VECS[i].e_blk, VECS[i].e_unb, VECS[i].e_emp);
    end

    // R9: overflow of the 8-entry skid while stalled
    drive(4, 8'hC0, 3'd1, 3'd0, 1'b0, 1'b0);
    expect_out("R9 fill 4", 3'd2, 0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    drive(4, 8'hD0, 3'd0, 3'd0, 1'b0, 1'b0);
    expect_bit("R9 full at capacity", skid_full, 1'b1);
    expect_bit("R9 no overflow yet", ovf_err, 1'b0);
    drive(4, 8'hE0, 3'd0, 3'd0, 1'b0, 1'b0);
    expect_bit("R9 overflow flagged", ovf_err, 1'b1);
    drive(0, 8'h00, 3'd0, 3'd1, 1'b0, 1'b0);
    expect_out("R9 drain 1", 3'd3, 2, 8'hC0, 8'hC1, 1'b0, 1'b0, 1'b0);
    drive(0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0);
    expect_out("R9 drain 2", 3'd3, 2, 8'hC2, 8'hC3, 1'b0, 1'b0, 1'b0);
    drive(0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0);
    expect_out("R9 drain 3", 3'd3, 2, 8'hD0, 8'hD1, 1'b0, 1'b0, 1'b0);
    drive(0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0);
    expect_out("R9 drain 4", 3'd1, 2, 8'hD2, 8'hD3, 1'b0, 1'b1, 1'b1);
    expect_bit("R9 overflow sticky", ovf_err, 1'b1);

    // R1: reset clears the sticky flag
    do_reset();
    expect_bit("R1 ovf cleared", ovf_err, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule